// File: doc/BRIEF.md
# Increment-and-Skip Step Sequencer

This block is the control and datapath core of a small accumulator-style processor, cut down to one instruction class. A sequence counter walks the numbered timing steps T0 to T6. In the first three steps the block fetches an instruction word from its own word-addressed store and decodes it. The remaining steps resolve the operand address, either directly or through one level of indirection. They then execute increment-and-skip-if-zero. That instruction reads a memory word into a data register, adds one, writes the word back, and advances the program counter past the next instruction when the result is zero.

A testbench or boot agent fills the store through a preload write port. It then raises `run` and watches the step number, the architectural registers and a one-cycle completion pulse. While `run` is low the sequencer freezes at its current step. Opcodes other than increment-and-skip are fetched and decoded but do nothing more. They end after the address step.

Top module: `isz_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `pc_o`, `ar_o`, `ir_o`, `dr_o`, `done_o` and the step number, so `step_o` reads 0 (T0).
- R2: `step_o` carries the number k of the current step Tk. In T0 the address register takes the program counter. In T1 the instruction register takes the word at address `ar_o`, and the program counter increments in the same step.
- R3: Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. In T2 the address register takes bits 11:0, and the indirect flag and the one-hot opcode decode are latched.
- R4: A direct increment-and-skip instruction (opcode 110, bit 15 = 0) passes through steps 0,1,2,3,4,5,6 on consecutive running cycles with no transfer in T3. After T6 the step returns to 0.
- R5: When bit 15 is 1, T3 replaces the address register with the low 12 bits of the word at the current address register. Execution then uses that effective address, and the pointer word is not modified.
- R6: In T4 the data register takes the word at the effective address. In T5 it increments by one modulo 2^16, so 16'hFFFF becomes 0.
- R7: In T6 the data register is written back to the effective address.
- R8: In T6, if the data register is zero, the program counter increments again, so it ends at 2 for an instruction fetched from address 0. Otherwise it ends at 1.
- R9: For any opcode other than 110, the instruction ends after T3. Memory is not written and the program counter ends one past the instruction.
- R10: While `run` is low, the step number and all registers hold their values.
- R11: A preload write (`ld_en`) in the same cycle as the T6 write-back to the same address wins. The preload data is stored.
- R12: `done_o` is high for exactly the one cycle after the final step of an instruction (T6, or T3 for other opcodes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance enable for the step sequence |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | MEM_AW | Preload word address |
| ld_data | input | 16 | Preload word |
| obs_addr | input | MEM_AW | Store observation address |
| obs_data | output | 16 | Store word at `obs_addr` (combinational) |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| ir_o | output | 16 | Instruction register |
| dr_o | output | 16 | Data register |
| step_o | output | 3 | Current timing step number |
| done_o | output | 1 | One-cycle instruction completion pulse |

## Verification
Two store writes can land in the same cycle: the T6 write-back and a preload from the outside port. The bench stops an increment-and-skip instruction one cycle before the T6 edge. It then drives a preload to the operand address, so both writes hit the same edge. The pass condition is that the observed word equals the preload value and not the incremented operand. The skip decision must still follow the data register, so the program counter ends at 2 for an operand of all ones.

// File: rtl/isz_pkg.sv
package isz_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned OPC_W   = 3;
    localparam int unsigned OPC_N   = 1 << OPC_W;
    localparam int unsigned OPC_LSB = ADDR_W;
    localparam int unsigned IND_BIT = WORD_W - 1;
    localparam int unsigned ISZ_OPC = 6;

    typedef enum logic [2:0] {
        ST_T0 = 3'd0,
        ST_T1 = 3'd1,
        ST_T2 = 3'd2,
        ST_T3 = 3'd3,
        ST_T4 = 3'd4,
        ST_T5 = 3'd5,
        ST_T6 = 3'd6
    } step_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] dr;
        logic              ind;
        logic [OPC_N-1:0]  dec;
        step_e             step;
        logic              done;
    } core_s;
endpackage

// File: rtl/isz_decode.sv
module isz_decode #(
    parameter int unsigned OPC_W = 3,
    localparam int unsigned OPC_N = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic [OPC_N-1:0] onehot
);
    for (genvar g = 0; g < OPC_N; g++) begin : g_line
        assign onehot[g] = (opc == OPC_W'(g));
    end
endmodule

// File: rtl/isz_stepper.sv
module isz_stepper
    import isz_pkg::*;
(
    input  logic  run,
    input  step_e step_q,
    input  logic  short_exit,
    output step_e step_d,
    output logic  fin
);
    always_comb begin
        step_d = step_q;
        fin    = 1'b0;
        if (run) begin
            case (step_q)
                ST_T3: begin
                    if (short_exit) begin
                        step_d = ST_T0;
                        fin    = 1'b1;
                    end else begin
                        step_d = ST_T4;
                    end
                end
                ST_T6: begin
                    step_d = ST_T0;
                    fin    = 1'b1;
                end
                default: step_d = step_e'(step_q + 3'd1);
            endcase
        end
    end
endmodule

// File: rtl/isz_mem.sv
module isz_mem #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 10,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] cells [DEPTH];

    // later assignment wins: preload overrides write-back on a shared address
    always_ff @(posedge clk) begin
        if (wb_en) cells[wb_addr] <= wb_data;
        if (ld_en) cells[ld_addr] <= ld_data;
    end

    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];
endmodule

// File: rtl/isz_seq.sv
module isz_seq
    import isz_pkg::*;
#(
    parameter int unsigned MEM_AW = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                ld_en,
    input  logic [MEM_AW-1:0]   ld_addr,
    input  logic [WORD_W-1:0]   ld_data,
    input  logic [MEM_AW-1:0]   obs_addr,
    output logic [WORD_W-1:0]   obs_data,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   ar_o,
    output logic [WORD_W-1:0]   ir_o,
    output logic [WORD_W-1:0]   dr_o,
    output logic [2:0]          step_o,
    output logic                done_o
);
    core_s             cur_q, nxt_d;
    logic [WORD_W-1:0] rd_word;
    logic [OPC_N-1:0]  dec_w;
    step_e             step_d;
    logic              fin_d;
    logic              wb_en;

    isz_decode #(.OPC_W(OPC_W)) u_dec (
        .opc    (cur_q.ir[OPC_LSB +: OPC_W]),
        .onehot (dec_w)
    );

    isz_stepper u_step (
        .run        (run),
        .step_q     (cur_q.step),
        .short_exit (!cur_q.dec[ISZ_OPC]),
        .step_d     (step_d),
        .fin        (fin_d)
    );

    assign wb_en = run && (cur_q.step == ST_T6);

    isz_mem #(.DW(WORD_W), .AW(MEM_AW)) u_mem (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .wb_en   (wb_en),
        .wb_addr (cur_q.ar[MEM_AW-1:0]),
        .wb_data (cur_q.dr),
        .ra_addr (cur_q.ar[MEM_AW-1:0]),
        .ra_data (rd_word),
        .rb_addr (obs_addr),
        .rb_data (obs_data)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = fin_d;
        nxt_d.step = step_d;
        if (run) begin
            case (cur_q.step)
                ST_T0: nxt_d.ar = cur_q.pc;
                ST_T1: begin
                    nxt_d.ir = rd_word;
                    nxt_d.pc = cur_q.pc + 1'b1;
                end
                ST_T2: begin
                    nxt_d.ar  = cur_q.ir[ADDR_W-1:0];
                    nxt_d.ind = cur_q.ir[IND_BIT];
                    nxt_d.dec = dec_w;
                end
                ST_T3: begin
                    if (cur_q.ind) nxt_d.ar = rd_word[ADDR_W-1:0];
                end
                ST_T4: nxt_d.dr = rd_word;
                ST_T5: nxt_d.dr = cur_q.dr + 1'b1;
                ST_T6: begin
                    if (cur_q.dr == '0) nxt_d.pc = cur_q.pc + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign pc_o   = cur_q.pc;
    assign ar_o   = cur_q.ar;
    assign ir_o   = cur_q.ir;
    assign dr_o   = cur_q.dr;
    assign step_o = cur_q.step;
    assign done_o = cur_q.done;
endmodule

// File: rtl/isz_seq_chk.sv
module isz_seq_chk
    import isz_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [2:0]        step_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] ar_o,
    input logic [WORD_W-1:0] dr_o,
    input logic              done_o
);
    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_o <= 3'd6);

    // R4
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (run && step_o != 3'd3 && step_o != 3'd6) |=> (step_o == $past(step_o) + 3'd1));

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (run && step_o == 3'd0) |=> (ar_o == $past(pc_o)));

    // R2
    fetch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (run && step_o == 3'd1) |=> (pc_o == $past(pc_o) + 1'b1));

    // R6
    dr_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (run && step_o == 3'd5) |=> (dr_o == $past(dr_o) + 1'b1));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(step_o) && $stable(pc_o) && $stable(ar_o) && $stable(dr_o)));

    // R12
    done_after_t6_chk: assert property (@(posedge clk) disable iff (rst)
        (run && step_o == 3'd6) |=> (done_o && step_o == 3'd0));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind isz_seq isz_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .step_o (step_o),
    .pc_o   (pc_o),
    .ar_o   (ar_o),
    .dr_o   (dr_o),
    .done_o (done_o)
);

// File: tb/tb_isz_seq.sv
module tb_isz_seq;
    localparam int MEM_AW = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic              ld_en = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [15:0]       ld_data = '0;
    logic [MEM_AW-1:0] obs_addr = '0;
    logic [15:0]       obs_data;
    logic [11:0]       pc_o, ar_o;
    logic [15:0]       ir_o, dr_o;
    logic [2:0]        step_o;
    logic              done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    isz_seq #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst(rst), .run(run),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .obs_addr(obs_addr), .obs_data(obs_data),
        .pc_o(pc_o), .ar_o(ar_o), .ir_o(ir_o), .dr_o(dr_o),
        .step_o(step_o), .done_o(done_o)
    );

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        run = 1'b0;
        rst = 1'b1;
        cycle();
        cycle();
        rst = 1'b0;
    endtask

    task automatic load(input logic [MEM_AW-1:0] a, input logic [15:0] d);
        ld_en   = 1'b1;
        ld_addr = a;
        ld_data = d;
        cycle();
        ld_en   = 1'b0;
    endtask

    task automatic peek(input logic [MEM_AW-1:0] a, output logic [15:0] d);
        obs_addr = a;
        #0.1;
        d = obs_data;
    endtask

    task automatic run_instr(input bit ind, input int opc, input logic [11:0] fld,
                             input logic [11:0] tgt, input logic [15:0] opnd);
        logic [15:0] w, m;
        logic [11:0] ea;
        logic [15:0] res;
        bit          isz;
        int          last;
        w    = {ind, 3'(opc), fld};
        ea   = ind ? tgt : fld;
        isz  = (opc == 6);
        res  = opnd + 16'd1;
        last = isz ? 7 : 4;
        do_reset();
        // R1
        check("R1 step", 32'(step_o), 0);
        check("R1 pc", 32'(pc_o), 0);
        check("R1 done", 32'(done_o), 0);
        load(0, w);
        load(1, 16'h0000);
        if (ind) load(fld[MEM_AW-1:0], {4'h0, tgt});
        load(ea[MEM_AW-1:0], opnd);
        run = 1'b1;
        for (int k = 1; k <= last; k++) begin
            cycle();
            if (k < last) begin
                // R4 / R9 step number
                check(isz ? "R4 step" : "R9 step", 32'(step_o), 32'(k));
                check("R12 no early done", 32'(done_o), 0);
            end
            if (k == 1) check("R2 ar<-pc", 32'(ar_o), 0);
            if (k == 2) begin
                check("R2 ir", 32'(ir_o), 32'(w));
                check("R2 pc+1", 32'(pc_o), 1);
            end
            if (k == 3) check("R3 ar<-field", 32'(ar_o), 32'(fld));
            if (k == 4 && isz) check(ind ? "R5 indirect ea" : "R4 idle T3", 32'(ar_o), 32'(ea));
            if (k == 5) check("R6 dr load", 32'(dr_o), 32'(opnd));
            if (k == 6) check("R6 dr incr", 32'(dr_o), 32'(res));
        end
        run = 1'b0;
        check("R12 done", 32'(done_o), 1);
        check(isz ? "R4 back to T0" : "R9 back to T0", 32'(step_o), 0);
        peek(ea[MEM_AW-1:0], m);
        if (isz) begin
            check("R7 writeback", 32'(m), 32'(res));
            check("R8 pc skip", 32'(pc_o), (res == 16'd0) ? 2 : 1);
        end else begin
            check("R9 mem untouched", 32'(m), 32'(opnd));
            check("R9 pc", 32'(pc_o), 1);
        end
        if (ind) begin
            peek(fld[MEM_AW-1:0], m);
            check("R5 pointer kept", 32'(m), 32'({4'h0, tgt}));
        end
        cycle();
        check("R12 pulse width", 32'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] ops [6];
        logic [15:0] m;
        ops = '{16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF, 16'hFFFE, 16'h8000};

        // increment-and-skip sweep, direct and indirect
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 6; j++) begin
                run_instr(i[0], 6, 12'h0A0 + 12'(j), 12'h155 + 12'(j), ops[j]);
            end
        end
        // every other opcode, both address modes
        for (int op = 0; op < 8; op++) begin
            if (op == 6) continue;
            for (int i = 0; i < 2; i++) begin
                run_instr(i[0], op, 12'h0B0 + 12'(op), 12'h1C0 + 12'(op), 16'hFFFF);
            end
        end

        // R10: stall in the middle of execution
        do_reset();
        load(0, {1'b0, 3'd6, 12'h0C0});
        load(12'h0C0, 16'h0041);
        run = 1'b1;
        repeat (4) cycle();
        check("R10 at T4", 32'(step_o), 4);
        run = 1'b0;
        for (int s = 0; s < 3; s++) begin
            cycle();
            check("R10 step held", 32'(step_o), 4);
            check("R10 pc held", 32'(pc_o), 1);
            check("R10 ar held", 32'(ar_o), 12'h0C0);
        end
        run = 1'b1;
        repeat (3) cycle();
        run = 1'b0;
        check("R10 done after resume", 32'(done_o), 1);
        peek(10'h0C0, m);
        check("R10 result", 32'(m), 16'h0042);
        check("R10 pc", 32'(pc_o), 1);

        // R11: preload collides with T6 write-back
        do_reset();
        load(0, {1'b0, 3'd6, 12'h0D0});
        load(12'h0D0, 16'hFFFF);
        run = 1'b1;
        repeat (6) cycle();
        check("R11 at T6", 32'(step_o), 6);
        ld_en   = 1'b1;
        ld_addr = 10'h0D0;
        ld_data = 16'h1234;
        cycle();
        ld_en = 1'b0;
        run   = 1'b0;
        peek(10'h0D0, m);
        check("R11 preload wins", 32'(m), 16'h1234);
        check("R11 skip kept", 32'(pc_o), 2);
        check("R11 done", 32'(done_o), 1);

        finish_up();
    end
endmodule